// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block takes a processor core from an instruction boundary into an interrupt handler in the classic real-mode way. The core raises an interrupt with an 8-bit vector number at any time. The block holds it pending until the core reports an instruction boundary. At that boundary it saves the return state on the stack and fetches the handler's code segment and instruction pointer from the vector table at the bottom of memory. It uses a simple word-wide memory port with a request/ready handshake.

While it is busy, or while the machine is halted, the block keeps the core's fetch-enable low. When the sequence finishes, it gives one completion pulse carrying the new CS, IP, SP and FLAGS for the core to load. A halt request is sticky until reset and outranks any pending interrupt. Vectors 0 and 2 are taken whatever the interrupt-enable flag says. All other vectors wait until it is set.

Top module: `rm_irq_entry`

## Requirements
- R1: A pulse on `raise_strobe` latches `raise_vec` and sets `irq_pending`. A later pulse before service replaces the latched vector, and the later vector is the one serviced.
- R2: A service sequence starts only in an idle cycle with `at_boundary` high. `fetch_go` is high only when the block is idle, `at_boundary` is high, the block is not halted and no service starts. It is low throughout a sequence.
- R3: `halt_req` sets `halted`, which stays set until reset. While halted, or while `halt_req` is high, no sequence starts and `fetch_go` stays low, even with an interrupt pending.
- R4: Vectors 0 and 2 are serviced while `if_en` is low. Any other vector stays pending, with `fetch_go` high at boundaries, until `if_en` is high.
- R5: A sequence performs exactly five memory transfers, in this order: write FLAGS, write CS, read the new CS from vector*4+2, write IP, read the new IP from vector*4.
- R6: Every memory address is (segment*16 + offset) mod 2^20. Stack transfers use `ss_in` as the segment. Vector-table reads use segment 0.
- R7: Each push first lowers SP by 2 modulo 2^16 and then writes at the new SP. At completion `new_sp` equals the entry SP minus 6, modulo 2^16.
- R8: The pushed FLAGS word is the unmodified `flags_in` value. `new_flags` is that value with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R9: A transfer holds `mem_req` high with stable address, direction and write data until `mem_rdy` is high, and only then moves on to the next transfer.
- R10: One cycle after the final read is accepted, `entry_done` is high for exactly one cycle. During that cycle `new_cs` and `new_ip` hold the words read from the table. `irq_pending` is low from that cycle on unless a new raise arrived.
- R11: A synchronous reset clears the pending interrupt, the halted state and the sequencer, so `fetch_go` is high at the first boundary after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raise_strobe | input | 1 | Raise the interrupt given by `raise_vec` |
| raise_vec | input | 8 | Vector number to raise |
| halt_req | input | 1 | Request to halt the machine |
| at_boundary | input | 1 | Core sits between instructions, before the next opcode fetch |
| if_en | input | 1 | Interrupt-enable flag of the core |
| flags_in | input | 16 | Current FLAGS word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer (return address) |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Transfer accepted this cycle |
| fetch_go | output | 1 | Core may fetch the next opcode |
| halted | output | 1 | Machine is halted |
| irq_pending | output | 1 | An interrupt is latched and not yet serviced |
| entry_done | output | 1 | One-cycle pulse: load the new state below |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler instruction pointer |
| new_sp | output | 16 | Stack pointer after the three pushes |
| new_flags | output | 16 | FLAGS with interrupt enable and trap cleared |

## Verification
Every cycle, the assertions check these rules: a stalled transfer holds still, halting shuts out both fetch and service, a sequence starts only at a boundary, and the enable gate is respected for every vector other than 0 and 2. They also check that fetch is never granted while a transfer is outstanding, that the completion clears the pending interrupt, and that the completion flags have both control bits cleared. Only the bench's scenarios can show the rest. These are the exact order and addresses of the five transfers, stack and segment wrap-around, the saved words, the table words reaching `new_cs`/`new_ip`, and a re-raise replacing the vector. Randomly stalled memory handshakes run throughout.

// File: rtl/rm_irq_pkg.sv
package rm_irq_pkg;
  localparam int WORD_W    = 16;
  localparam int VEC_W     = 8;
  localparam int SEG_SHIFT = 4;
  localparam int ADDR_W    = WORD_W + SEG_SHIFT;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [ADDR_W-1:0] paddr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_LOAD_CS,
    ST_PUSH_IP,
    ST_LOAD_IP,
    ST_DONE
  } step_e;

  // segment:offset to physical, wrapping at the address width
  function automatic paddr_t seg_addr(word_t seg, word_t off);
    return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  endfunction

  // stack pre-decrement by one word, modulo 2^WORD_W
  function automatic word_t sp_dec(word_t sp);
    return sp - WORD_W'(2);
  endfunction

  // table offset of a vector: vec*4, plus 2 for the segment half
  function automatic word_t vec_off(vec_t v, logic seg_half);
    return {{(WORD_W-VEC_W-2){1'b0}}, v, seg_half, 1'b0};
  endfunction

  // vectors that ignore the interrupt-enable gate
  function automatic logic gate_bypass(vec_t v);
    return (v == VEC_W'(0)) || (v == VEC_W'(2));
  endfunction
endpackage

// File: rtl/rm_irq_gate.sv
module rm_irq_gate
  import rm_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic raise_strobe,
  input  vec_t raise_vec,
  input  logic halt_req,
  input  logic at_boundary,
  input  logic if_en,
  input  logic seq_idle,
  input  logic clear_pend,
  output logic pending,
  output vec_t pend_vec,
  output logic halted,
  output logic svc_start,
  output logic fetch_go
);
  logic blocked;
  logic eligible;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      pend_vec <= '0;
    end else if (raise_strobe) begin
      pending  <= 1'b1;
      pend_vec <= raise_vec;
    end else if (clear_pend) begin
      pending  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           halted <= 1'b0;
    else if (halt_req) halted <= 1'b1;
  end

  always_comb begin
    blocked   = halted | halt_req;
    eligible  = pending & (if_en | gate_bypass(pend_vec));
    svc_start = seq_idle & at_boundary & ~blocked & eligible;
    fetch_go  = seq_idle & at_boundary & ~blocked & ~svc_start;
  end
endmodule

// File: rtl/rm_irq_port.sv
module rm_irq_port
  import rm_irq_pkg::*;
(
  input  step_e  step,
  input  word_t  sp_cur,
  input  word_t  ss_r,
  input  word_t  flags_r,
  input  word_t  cs_r,
  input  word_t  ip_r,
  input  vec_t   vec_r,
  output logic   mem_req,
  output logic   mem_we,
  output paddr_t mem_addr,
  output word_t  mem_wdata
);
  word_t push_sp;

  always_comb begin
    push_sp   = sp_dec(sp_cur);
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (step)
      ST_PUSH_FL: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = seg_addr(ss_r, push_sp); mem_wdata = flags_r;
      end
      ST_PUSH_CS: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = seg_addr(ss_r, push_sp); mem_wdata = cs_r;
      end
      ST_LOAD_CS: begin
        mem_req = 1'b1;
        mem_addr = seg_addr('0, vec_off(vec_r, 1'b1));
      end
      ST_PUSH_IP: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = seg_addr(ss_r, push_sp); mem_wdata = ip_r;
      end
      ST_LOAD_IP: begin
        mem_req = 1'b1;
        mem_addr = seg_addr('0, vec_off(vec_r, 1'b0));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rm_irq_seq.sv
module rm_irq_seq
  import rm_irq_pkg::*;
#(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  svc_start,
  input  vec_t  vec_in,
  input  word_t flags_in,
  input  word_t cs_in,
  input  word_t ip_in,
  input  word_t sp_in,
  input  word_t ss_in,
  input  logic  mem_req,
  input  logic  mem_rdy,
  input  word_t mem_rdata,
  output step_e step,
  output logic  seq_idle,
  output logic  clear_pend,
  output logic  entry_done,
  output vec_t  vec_r,
  output word_t flags_r,
  output word_t cs_r,
  output word_t ip_r,
  output word_t sp_r,
  output word_t ss_r,
  output word_t new_cs,
  output word_t new_ip,
  output word_t new_flags
);
  localparam word_t CTRL_MASK = word_t'((1 << IF_BIT) | (1 << TF_BIT));

  logic ack;

  assign ack        = mem_req & mem_rdy;
  assign seq_idle   = (step == ST_IDLE);
  assign clear_pend = ack & (step == ST_LOAD_IP);
  assign entry_done = (step == ST_DONE);
  assign new_flags  = flags_r & ~CTRL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= ST_IDLE;
      vec_r   <= '0;
      flags_r <= '0;
      cs_r    <= '0;
      ip_r    <= '0;
      sp_r    <= '0;
      ss_r    <= '0;
      new_cs  <= '0;
      new_ip  <= '0;
    end else begin
      unique case (step)
        ST_IDLE: if (svc_start) begin
          vec_r   <= vec_in;
          flags_r <= flags_in;
          cs_r    <= cs_in;
          ip_r    <= ip_in;
          sp_r    <= sp_in;
          ss_r    <= ss_in;
          step    <= ST_PUSH_FL;
        end
        ST_PUSH_FL: if (ack) begin
          sp_r <= sp_dec(sp_r);
          step <= ST_PUSH_CS;
        end
        ST_PUSH_CS: if (ack) begin
          sp_r <= sp_dec(sp_r);
          step <= ST_LOAD_CS;
        end
        ST_LOAD_CS: if (ack) begin
          new_cs <= mem_rdata;
          step   <= ST_PUSH_IP;
        end
        ST_PUSH_IP: if (ack) begin
          sp_r <= sp_dec(sp_r);
          step <= ST_LOAD_IP;
        end
        ST_LOAD_IP: if (ack) begin
          new_ip <= mem_rdata;
          step   <= ST_DONE;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_irq_entry.sv
module rm_irq_entry
  import rm_irq_pkg::*;
#(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_strobe,
  input  logic [VEC_W-1:0]  raise_vec,
  input  logic              halt_req,
  input  logic              at_boundary,
  input  logic              if_en,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] ss_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic              fetch_go,
  output logic              halted,
  output logic              irq_pending,
  output logic              entry_done,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_sp,
  output logic [WORD_W-1:0] new_flags
);
  // events shared between the pieces, named for the checker
  logic  svc_start;
  logic  seq_idle;
  logic  clear_pend;
  vec_t  pend_vec;
  step_e step;
  vec_t  vec_r;
  word_t flags_r, cs_r, ip_r, sp_r, ss_r;

  rm_irq_gate u_gate (
    .clk(clk), .rst(rst),
    .raise_strobe(raise_strobe), .raise_vec(raise_vec),
    .halt_req(halt_req), .at_boundary(at_boundary), .if_en(if_en),
    .seq_idle(seq_idle), .clear_pend(clear_pend),
    .pending(irq_pending), .pend_vec(pend_vec), .halted(halted),
    .svc_start(svc_start), .fetch_go(fetch_go)
  );

  rm_irq_seq #(.IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_seq (
    .clk(clk), .rst(rst), .svc_start(svc_start), .vec_in(pend_vec),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
    .sp_in(sp_in), .ss_in(ss_in),
    .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .step(step), .seq_idle(seq_idle), .clear_pend(clear_pend),
    .entry_done(entry_done), .vec_r(vec_r),
    .flags_r(flags_r), .cs_r(cs_r), .ip_r(ip_r), .sp_r(sp_r), .ss_r(ss_r),
    .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags)
  );

  rm_irq_port u_port (
    .step(step), .sp_cur(sp_r), .ss_r(ss_r), .flags_r(flags_r),
    .cs_r(cs_r), .ip_r(ip_r), .vec_r(vec_r),
    .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign new_sp = sp_r;
endmodule

// File: rtl/rm_irq_entry_chk.sv
module rm_irq_entry_chk
  import rm_irq_pkg::*;
#(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              at_boundary,
  input logic              raise_strobe,
  input logic              if_en,
  input logic              mem_req,
  input logic              mem_rdy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              fetch_go,
  input logic              halted,
  input logic              irq_pending,
  input logic              entry_done,
  input logic [WORD_W-1:0] new_flags,
  input logic              svc_start,
  input logic [VEC_W-1:0]  pend_vec
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_halt_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    halted |-> !fetch_go && !svc_start);

  p_start_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    svc_start |-> at_boundary && irq_pending);

  p_no_fetch_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req || entry_done) |-> !fetch_go);

  p_if_gate_r4: assert property (@(posedge clk) disable iff (rst)
    svc_start |-> if_en || pend_vec == VEC_W'(0) || pend_vec == VEC_W'(2));

  p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
    entry_done && !$past(raise_strobe) |-> !irq_pending);

  p_flags_masked_r8: assert property (@(posedge clk) disable iff (rst)
    entry_done |-> !new_flags[IF_BIT] && !new_flags[TF_BIT]);
endmodule

bind rm_irq_entry rm_irq_entry_chk #(.IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_chk (
  .clk(clk), .rst(rst), .at_boundary(at_boundary), .raise_strobe(raise_strobe),
  .if_en(if_en), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fetch_go(fetch_go),
  .halted(halted), .irq_pending(irq_pending), .entry_done(entry_done),
  .new_flags(new_flags), .svc_start(svc_start), .pend_vec(pend_vec)
);

// File: tb/rm_irq_entry_bench.sv
module rm_irq_entry_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise_strobe = 1'b0;
  logic [7:0]  raise_vec = '0;
  logic        halt_req = 1'b0;
  logic        at_boundary = 1'b0;
  logic        if_en = 1'b0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, sp_in = '0, ss_in = '0;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;
  logic        fetch_go, halted, irq_pending, entry_done;
  logic [15:0] new_cs, new_ip, new_sp, new_flags;

  int total = 0;
  int bad = 0;

  // transfer log filled by the memory model
  logic [19:0] lg_addr [0:7];
  logic        lg_we   [0:7];
  logic [15:0] lg_data [0:7];
  int          lg_n = 0;
  bit          stall_on = 1'b1;

  rm_irq_entry u_rm_irq_entry (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [19:0] phys(logic [15:0] seg, logic [15:0] off);
    int unsigned s;
    s = (32'(seg) * 16) + 32'(off);
    return s[19:0];
  endfunction

  function automatic logic [15:0] table_word(logic [19:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[19:16], 12'h0};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: decides ready anew on every falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && (!stall_on || ($urandom % 3) != 0)) begin
        mem_rdy = 1'b1;
        mem_rdata = table_word(mem_addr);
        if (lg_n < 8) begin
          lg_addr[lg_n] = mem_addr;
          lg_we[lg_n]   = mem_we;
          lg_data[lg_n] = mem_we ? mem_wdata : mem_rdata;
        end
        lg_n++;
      end else begin
        mem_rdy = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic raise(logic [7:0] v);
    @(negedge clk);
    raise_vec = v; raise_strobe = 1'b1;
    @(negedge clk);
    raise_strobe = 1'b0;
  endtask

  // run one full entry and compare every transfer and result
  task automatic entry(logic [7:0] v, logic [15:0] fl, logic [15:0] cs,
                       logic [15:0] ip, logic [15:0] sp, logic [15:0] ss, logic ie);
    logic [19:0] ea [0:4];
    logic        ew [0:4];
    logic [15:0] ed [0:4];
    int n;
    bit busy_fetch;
    flags_in = fl; cs_in = cs; ip_in = ip; sp_in = sp; ss_in = ss; if_en = ie;
    at_boundary = 1'b0;
    raise(v);
    lg_n = 0;
    busy_fetch = 1'b0;
    at_boundary = 1'b1;
    n = 0;
    while (!entry_done && n < 300) begin
      @(negedge clk);
      if (mem_req && fetch_go) busy_fetch = 1'b1;
      n++;
    end
    ea[0] = phys(ss, sp - 16'd2); ew[0] = 1; ed[0] = fl;
    ea[1] = phys(ss, sp - 16'd4); ew[1] = 1; ed[1] = cs;
    ea[2] = phys(16'h0, {6'b0, v, 2'b10}); ew[2] = 0; ed[2] = table_word(ea[2]);
    ea[3] = phys(ss, sp - 16'd6); ew[3] = 1; ed[3] = ip;
    ea[4] = phys(16'h0, {6'b0, v, 2'b00}); ew[4] = 0; ed[4] = table_word(ea[4]);
    chk(entry_done == 1'b1, "R10 done pulse", 32'(entry_done), 32'd1);
    chk(lg_n == 5, "R5 transfer count", 32'(lg_n), 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk(lg_addr[i] == ea[i], "R6 R7 transfer address", 32'(lg_addr[i]), 32'(ea[i]));
      chk(lg_we[i] == ew[i], "R5 transfer direction", 32'(lg_we[i]), 32'(ew[i]));
      chk(lg_data[i] == ed[i], "R5 R8 transfer data", 32'(lg_data[i]), 32'(ed[i]));
    end
    chk(new_cs == ed[2], "R10 new_cs", 32'(new_cs), 32'(ed[2]));
    chk(new_ip == ed[4], "R10 new_ip", 32'(new_ip), 32'(ed[4]));
    chk(new_sp == sp - 16'd6, "R7 new_sp", 32'(new_sp), 32'(sp - 16'd6));
    chk(new_flags == (fl & 16'hFCFF), "R8 new_flags", 32'(new_flags), 32'(fl & 16'hFCFF));
    chk(!busy_fetch, "R2 no fetch while busy", 32'(busy_fetch), 32'd0);
    @(negedge clk);
    chk(!entry_done, "R10 single pulse", 32'(entry_done), 32'd0);
    chk(!irq_pending, "R10 pending cleared", 32'(irq_pending), 32'd0);
    chk(fetch_go, "R2 fetch resumes", 32'(fetch_go), 32'd1);
    at_boundary = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    at_boundary = 1'b1;
    @(negedge clk);
    chk(fetch_go && !halted && !irq_pending && !mem_req, "R11 reset state",
        {28'd0, fetch_go, halted, irq_pending, mem_req}, 32'h8);

    // R4: bypass vectors with the enable flag clear
    entry(8'd0, 16'h0302, 16'h1234, 16'h0100, 16'h0400, 16'h2000, 1'b0);
    entry(8'd2, 16'hFFFF, 16'hF000, 16'hFFF0, 16'h8000, 16'h0030, 1'b0);

    // R4: gated vector waits while enable is clear
    at_boundary = 1'b0; if_en = 1'b0;
    raise(8'd5);
    lg_n = 0;
    at_boundary = 1'b1;
    repeat (20) @(negedge clk);
    chk(lg_n == 0, "R4 gated vector no transfer", 32'(lg_n), 32'd0);
    chk(fetch_go && irq_pending, "R4 gated vector fetch allowed",
        {30'd0, fetch_go, irq_pending}, 32'h3);
    at_boundary = 1'b0;
    raise(8'd5);
    entry(8'd5, 16'h0200, 16'h0040, 16'h0008, 16'h0100, 16'h0050, 1'b1);

    // R1: overwrite before service
    at_boundary = 1'b0;
    raise(8'd7);
    entry(8'd9, 16'h0046, 16'h0707, 16'h0202, 16'h0800, 16'h0900, 1'b1);

    // R7 stack wrap, R6 physical wrap, top vector, no stalls
    stall_on = 1'b0;
    entry(8'd255, 16'h0001, 16'hABCD, 16'h1111, 16'h0002, 16'h1000, 1'b1);
    stall_on = 1'b1;
    entry(8'd200, 16'h0100, 16'h0001, 16'h2222, 16'h0020, 16'hFFFF, 1'b1);

    // random entries with random stalls (R9)
    for (int k = 0; k < 30; k++) begin
      entry(8'($urandom_range(0, 255)), 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), 16'($urandom), 1'b1);
    end

    // R3: halt outranks a pending, enabled interrupt
    at_boundary = 1'b0; if_en = 1'b1;
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    raise(8'd2);
    lg_n = 0;
    at_boundary = 1'b1;
    begin
      int fg;
      fg = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (fetch_go) fg++;
      end
      chk(halted, "R3 halted sticky", 32'(halted), 32'd1);
      chk(lg_n == 0, "R3 no service while halted", 32'(lg_n), 32'd0);
      chk(fg == 0, "R3 no fetch while halted", 32'(fg), 32'd0);
    end

    // R11: reset clears halt and pending
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!halted && !irq_pending && fetch_go, "R11 reset clears",
        {29'd0, halted, irq_pending, fetch_go}, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule